// File: doc/BRIEF.md
# Processor Tick Timer

A cycle counter paired with a configuration register, meant to live in a small processor's special-register space. Software reaches both 32-bit registers through a minimal port set: a register select, a write strobe, write data and a combinational read-back. The counter advances once per clock while a counting mode is active. A match is the condition where the low 28 bits of the count equal the 28-bit period field.

What happens on a match depends on the mode. Auto-restart clears the count. One-shot freezes the count and stops. Continuous lets the count run on. Disabled never counts, but it still reports a match found right after a register write. A match can latch a sticky pending flag. The interrupt line is that flag gated by an enable bit. Software can clear the pending flag but can never set it.

Top module: `tick_timer`

## Requirements
- R1: Asynchronous reset (rst_ni low) clears the count and the configuration register and drives irq_o low. After reset the count stays at 0 until a counting mode is written.
- R2: Configuration layout: bits 31:30 select the mode (00 disabled, 01 auto-restart, 10 one-shot, 11 continuous), bit 29 enables the interrupt, bit 28 is the pending flag, and bits 27:0 are the period. irq_o is high only while both bit 29 and bit 28 are set. rdata_o returns the count when sel_i=0 and the configuration when sel_i=1.
- R3: A match is count[27:0] equal to the period while counting. This includes the step where the low 28 bits wrap from 0x0FFFFFFF to 0.
- R4: In auto-restart mode, the edge after the count shows a match loads 0, and counting carries on from there.
- R5: In one-shot mode, the edge after a match holds the count at the period value and stops counting. Counting stays stopped until the configuration is written again, and a write to the count does not restart it.
- R6: A match with the enable set and the pending flag clear sets the pending flag on the following edge, so irq_o rises one cycle after the matching count is visible.
- R7: In continuous mode the count keeps incrementing by one through a match, across the full 32 bits.
- R8: When counting is stopped, the count is compared once on the edge after any register write. If it equals the period and the enable is set, the pending flag is raised. Otherwise nothing happens.
- R9: A configuration write never sets the pending flag. Writing bit 28 as 1 keeps its current value, and writing it as 0 clears it, so irq_o drops right after the write edge.
- R10: A count write loads the written value. Counting continues from that value if a counting mode is running, and holds it otherwise. While stopped, reads return the held value.
- R11: Writing continuous mode while the full 32-bit count already equals the new period leaves the counter stopped.
- R12: On a write edge the count neither increments nor acts on a match, and the pending flag is not set by hardware. Any match against the new values is taken on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Register select: 0 count, 1 configuration |
| we_i | input | 1 | Write strobe for the selected register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Selected register, combinational |
| irq_o | output | 1 | Level interrupt: pending AND enable |

## Verification
A register write is visible on rdata_o right after its edge. A write of the count appears unchanged. A write of the configuration holds the count for that edge and shows the pending flag only ever cleared or kept. A match seen in the count at one sample produces its restart, freeze or interrupt at the next sample, one edge later, and a stopped-state match after a write also surfaces one edge after that write. The bench steps one clock edge per table row and reads outputs half a period after each edge, so every expected value in the table is the exact state after that edge.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int unsigned TICK_W = 32;
  localparam int unsigned CMP_W  = TICK_W - 4;

  typedef enum logic [1:0] {
    TM_OFF     = 2'b00,
    TM_RESTART = 2'b01,
    TM_ONESHOT = 2'b10,
    TM_CONT    = 2'b11
  } tick_mode_e;

  typedef struct packed {
    tick_mode_e         mode;
    logic               ie;
    logic               ip;
    logic [CMP_W-1:0]   period;
  } tick_cfg_t;
endpackage

// File: rtl/tick_cfg_reg.sv
module tick_cfg_reg
  import tick_pkg::*;
#(
  parameter int unsigned DATA_W = TICK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              set_ip_i,
  output tick_cfg_t         cfg_o
);
  tick_cfg_t cfg_q, cfg_wr;

  // software may only keep or clear the pending flag
  always_comb begin
    cfg_wr    = tick_cfg_t'(wdata_i);
    cfg_wr.ip = cfg_q.ip & wdata_i[DATA_W-4];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (wr_i)     cfg_q <= cfg_wr;
    else if (set_ip_i) cfg_q.ip <= 1'b1;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/tick_match.sv
module tick_match #(
  parameter int unsigned CMP_W = tick_pkg::CMP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_any_i,
  input  logic             run_i,
  input  logic [CMP_W-1:0] cnt_low_i,
  input  logic [CMP_W-1:0] period_i,
  output logic             hit_o
);
  logic chk_q;

  // one-shot compare window after any register write (stopped-state match)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chk_q <= 1'b0;
    else         chk_q <= wr_any_i;
  end

  assign hit_o = (cnt_low_i == period_i) && (run_i || chk_q);
endmodule

// File: rtl/tick_counter.sv
module tick_counter
  import tick_pkg::*;
#(
  parameter int unsigned CNT_W = TICK_W,
  parameter int unsigned CMP_W = tick_pkg::CMP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_cnt_i,
  input  logic             wr_cfg_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  tick_mode_e       mode_i,
  input  logic [CMP_W-1:0] period_i,
  input  logic             act_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o
);
  localparam int unsigned PAD_W = CNT_W - CMP_W;

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  tick_mode_e       new_mode;
  logic [CMP_W-1:0] new_period;
  logic             start;

  assign new_mode   = tick_mode_e'(wdata_i[CNT_W-1 -: 2]);
  assign new_period = wdata_i[CMP_W-1:0];
  // continuous start is refused when the count already sits on the period
  assign start = (new_mode != TM_OFF) &&
                 !(new_mode == TM_CONT && cnt_q == {{PAD_W{1'b0}}, new_period});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (wr_cnt_i) begin
      cnt_q <= wdata_i;
    end else if (wr_cfg_i) begin
      run_q <= start;
    end else if (run_q) begin
      if (act_i) begin
        unique case (mode_i)
          TM_RESTART: cnt_q <= '0;
          TM_ONESHOT: begin
            cnt_q <= {{PAD_W{1'b0}}, period_i};
            run_q <= 1'b0;
          end
          default:    cnt_q <= cnt_q + 1'b1;
        endcase
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [TICK_W-1:0] wdata_i,
  output logic [TICK_W-1:0] rdata_o,
  output logic              irq_o
);
  tick_cfg_t         cfg_q;
  logic [TICK_W-1:0] count_q;
  logic              run_q;
  logic              hit_c;
  logic              wr_cnt, wr_cfg, act, set_ip;

  assign wr_cnt = we_i && !sel_i;
  assign wr_cfg = we_i && sel_i;
  assign act    = hit_c && !we_i;
  assign set_ip = act && cfg_q.ie && !cfg_q.ip;

  tick_cfg_reg #(.DATA_W(TICK_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_cfg),
    .wdata_i  (wdata_i),
    .set_ip_i (set_ip),
    .cfg_o    (cfg_q)
  );

  tick_match #(.CMP_W(CMP_W)) u_match (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_any_i  (we_i),
    .run_i     (run_q),
    .cnt_low_i (count_q[CMP_W-1:0]),
    .period_i  (cfg_q.period),
    .hit_o     (hit_c)
  );

  tick_counter #(.CNT_W(TICK_W), .CMP_W(CMP_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_cnt_i (wr_cnt),
    .wr_cfg_i (wr_cfg),
    .wdata_i  (wdata_i),
    .mode_i   (cfg_q.mode),
    .period_i (cfg_q.period),
    .act_i    (act),
    .cnt_o    (count_q),
    .run_o    (run_q)
  );

  assign rdata_o = sel_i ? TICK_W'(cfg_q) : count_q;
  assign irq_o   = cfg_q.ip && cfg_q.ie;
endmodule

// File: rtl/tick_timer_checker.sv
module tick_timer_checker
  import tick_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              we_i,
  input logic [TICK_W-1:0] wdata_i,
  input logic [TICK_W-1:0] count_q,
  input tick_cfg_t         cfg_q,
  input logic              run_q,
  input logic              hit_c
);
  assert_no_sw_ip_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i && !cfg_q.ip) |=> !cfg_q.ip);

  assert_hold_when_stopped_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !we_i) |=> $stable(count_q));

  assert_restart_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !we_i && hit_c && cfg_q.mode == TM_RESTART) |=> count_q == '0);

  assert_oneshot_stop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !we_i && hit_c && cfg_q.mode == TM_ONESHOT)
      |=> (!run_q && count_q[CMP_W-1:0] == $past(cfg_q.period)));

  assert_cont_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !we_i && cfg_q.mode == TM_CONT) |=> count_q == $past(count_q) + 1'b1);

  assert_write_prio_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !sel_i) |=> (count_q == $past(wdata_i) && $stable(cfg_q.ip)));

  assert_ip_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && hit_c && cfg_q.ie && !cfg_q.ip) |=> cfg_q.ip);
endmodule

bind tick_timer tick_timer_checker u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sel_i   (sel_i),
  .we_i    (we_i),
  .wdata_i (wdata_i),
  .count_q (count_q),
  .cfg_q   (cfg_q),
  .run_q   (run_q),
  .hit_c   (hit_c)
);

// File: tb/tick_timer_tb_top.sv
module tick_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        wr;
    logic        sel;
    logic [31:0] data;
    logic [31:0] exp_cnt;
    logic        exp_irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 48;
  // wr=0 rows are idle cycles; every row advances one edge then checks count/irq
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,32'h6000_0005,32'd0,1'b0,4'd4},   // R4 restart mode, count held
    '{1'b0,1'b0,32'h0,32'd1,1'b0,4'd4},
    '{1'b0,1'b0,32'h0,32'd2,1'b0,4'd4},
    '{1'b0,1'b0,32'h0,32'd3,1'b0,4'd4},
    '{1'b0,1'b0,32'h0,32'd4,1'b0,4'd4},
    '{1'b0,1'b0,32'h0,32'd5,1'b0,4'd3},           // R3 match visible
    '{1'b0,1'b0,32'h0,32'd0,1'b1,4'd6},           // R6 R4 restart + irq
    '{1'b0,1'b0,32'h0,32'd1,1'b1,4'd6},
    '{1'b1,1'b1,32'h6000_0005,32'd1,1'b0,4'd9},   // R9 clear pending
    '{1'b0,1'b0,32'h0,32'd2,1'b0,4'd4},
    '{1'b0,1'b0,32'h0,32'd3,1'b0,4'd4},
    '{1'b0,1'b0,32'h0,32'd4,1'b0,4'd4},
    '{1'b0,1'b0,32'h0,32'd5,1'b0,4'd4},
    '{1'b1,1'b0,32'd2,32'd2,1'b0,4'd12},          // R12 write beats match
    '{1'b0,1'b0,32'h0,32'd3,1'b0,4'd10},          // R10 continues from written
    '{1'b1,1'b1,32'h0,32'd3,1'b0,4'd2},           // R2 disable
    '{1'b0,1'b0,32'h0,32'd3,1'b0,4'd2},
    '{1'b1,1'b0,32'd0,32'd0,1'b0,4'd10},
    '{1'b1,1'b1,32'hA000_0003,32'd0,1'b0,4'd5},   // R5 one-shot
    '{1'b0,1'b0,32'h0,32'd1,1'b0,4'd5},
    '{1'b0,1'b0,32'h0,32'd2,1'b0,4'd5},
    '{1'b0,1'b0,32'h0,32'd3,1'b0,4'd5},
    '{1'b0,1'b0,32'h0,32'd3,1'b1,4'd5},           // frozen, irq
    '{1'b0,1'b0,32'h0,32'd3,1'b1,4'd5},
    '{1'b0,1'b0,32'h0,32'd3,1'b1,4'd5},
    '{1'b1,1'b0,32'd7,32'd7,1'b1,4'd10},          // R10 load while stopped
    '{1'b0,1'b0,32'h0,32'd7,1'b1,4'd5},           // no restart on count write
    '{1'b1,1'b1,32'hA000_0009,32'd7,1'b0,4'd5},   // rearm one-shot
    '{1'b0,1'b0,32'h0,32'd8,1'b0,4'd5},
    '{1'b0,1'b0,32'h0,32'd9,1'b0,4'd5},
    '{1'b0,1'b0,32'h0,32'd9,1'b1,4'd5},
    '{1'b1,1'b1,32'h0,32'd9,1'b0,4'd9},
    '{1'b1,1'b0,32'h0FFF_FFFE,32'h0FFF_FFFE,1'b0,4'd10},
    '{1'b1,1'b1,32'hE000_0000,32'h0FFF_FFFE,1'b0,4'd7}, // R7 continuous, period 0
    '{1'b0,1'b0,32'h0,32'h0FFF_FFFF,1'b0,4'd3},
    '{1'b0,1'b0,32'h0,32'h1000_0000,1'b0,4'd3},   // R3 low bits wrapped
    '{1'b0,1'b0,32'h0,32'h1000_0001,1'b1,4'd3},
    '{1'b0,1'b0,32'h0,32'h1000_0002,1'b1,4'd7},
    '{1'b1,1'b1,32'h0,32'h1000_0002,1'b0,4'd2},
    '{1'b1,1'b0,32'd9,32'd9,1'b0,4'd10},
    '{1'b1,1'b1,32'hC000_0009,32'd9,1'b0,4'd11},  // R11 refused start
    '{1'b0,1'b0,32'h0,32'd9,1'b0,4'd11},
    '{1'b0,1'b0,32'h0,32'd9,1'b0,4'd11},
    '{1'b1,1'b1,32'h2000_0009,32'd9,1'b0,4'd8},   // R8 disabled, equal
    '{1'b0,1'b0,32'h0,32'd9,1'b1,4'd8},
    '{1'b1,1'b1,32'h2000_0005,32'd9,1'b0,4'd9},
    '{1'b0,1'b0,32'h0,32'd9,1'b0,4'd8},           // R8 mismatch: silent
    '{1'b0,1'b0,32'h0,32'd9,1'b0,4'd8}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          tests = 0, fails = 0;
  bit          finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_timer dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic do_write(input logic s, input logic [31:0] d);
    sel = s; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic read_both(input string req, input logic [31:0] exp_cfg,
                           input logic exp_irq);
    sel = 1'b1; #1;
    chk(req, "cfg", rdata, exp_cfg);
    chk(req, "irq", {31'd0, irq}, {31'd0, exp_irq});
  endtask

  initial begin
    #2;
    sel = 1'b0; #1;
    chk("R1", "reset count", rdata, 32'd0);
    sel = 1'b1; #1;
    chk("R1", "reset cfg", rdata, 32'd0);
    chk("R1", "reset irq", {31'd0, irq}, 32'd0);
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    sel = 1'b0; #1;
    chk("R1", "idle after reset", rdata, 32'd0);

    for (int i = 0; i < NV; i++) begin
      sel = VECS[i].sel; we = VECS[i].wr; wdata = VECS[i].data;
      @(negedge clk);
      we = 1'b0; sel = 1'b0; #1;
      chk($sformatf("R%0d", VECS[i].req), $sformatf("row %0d count", i),
          rdata, VECS[i].exp_cnt);
      chk($sformatf("R%0d", VECS[i].req), $sformatf("row %0d irq", i),
          {31'd0, irq}, {31'd0, VECS[i].exp_irq});
    end

    // state: disabled, count 9, pending clear
    @(negedge clk);
    do_write(1'b1, 32'h3000_0009);
    read_both("R9", 32'h2000_0009, 1'b0);     // sw cannot set pending
    @(negedge clk);
    read_both("R8", 32'h3000_0009, 1'b1);     // hw sets it after the write
    @(negedge clk);
    do_write(1'b1, 32'h3000_0005);
    read_both("R9", 32'h3000_0005, 1'b1);     // writing 1 keeps it
    @(negedge clk);
    do_write(1'b1, 32'h1000_0005);
    read_both("R2", 32'h1000_0005, 1'b0);     // irq gated by enable

    #2 rst_ni = 1'b0; #1;
    sel = 1'b0; #1;
    chk("R1", "async reset count", rdata, 32'd0);
    read_both("R1", 32'd0, 1'b0);
    @(negedge clk); rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    sel = 1'b0; #1;
    chk("R1", "no count after reset", rdata, 32'd0);

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule